// File: doc/BRIEF.md
# Memory-to-Stream Word DMA Read Channel

This block is a single-channel read engine. It fetches 32-bit words one at a time from a simple synchronous memory port and presents each word on a valid/ready stream output that also carries an end-of-packet marker. Software sets up a transfer through a small register port. It writes a word-aligned address, split into a low register and a 17-bit high register, plus a control word. Writing the byte count then starts the channel.

As words flow, the channel keeps an additive checksum of the raw fetched words. It can reverse the byte order of each outgoing word. It walks memory either with an incrementing address or at one fixed address. Two pause bits hold off new fetches. Completion and read-error events leave the block as single-cycle pulses for a separate interrupt block to collect. A zero-length start completes at once.

Top module: `m2s_dma`

Register indices on `reg_idx`: 0 address low, 1 address high, 2 size, 3 control, 4 checksum, 5 status (bit 0 busy). Control bits: bit 0 memory pause, bit 1 stream pause, bit 2 fixed address, bit 3 byte swap.

## Requirements
- R1: A write to index 0 keeps data bits [31:2] as the word-aligned low address, and reads back with bits [1:0] zero. A write to index 1 keeps bits [16:0] as address bits [48:32]. The byte address on `mem_addr` is {high, low}.
- R2: A write to index 2 keeps bits [28:2] as the byte count and latches bit 0 as the last-word flag. The register reads back as {3'b0, count[28:2], 1'b0, flag}. Bits 31:29 and bit 1 are dropped.
- R3: A nonzero size write while idle sets status bit 0 (busy) and starts fetching. The words appear on `m_tdata` in address order, taken from the programmed address.
- R4: A size write of zero while idle moves no data, leaves busy clear, and pulses `evt_done` and `evt_mem_done` once each.
- R5: Each stream handshake lowers the size readback by 4. It also raises the address by 4 when control bit 2 is 0, with the carry flowing into the high register. When control bit 2 is 1, the address stays fixed.
- R6: When the count reaches zero, busy clears and `evt_done` and `evt_mem_done` each pulse exactly once.
- R7: Index 4 is readable and writable. Each fetched raw word is added into it modulo 2^32.
- R8: With control bit 3 set, the output word has its bytes reversed (bits [7:0] go out in [31:24]). The checksum still adds the unswapped word.
- R9: `m_tlast` is high only on the final word of a transfer, and only when the latched last-word flag is 1.
- R10: While control bit 0 or bit 1 is set, no new word is fetched or offered. Clearing both bits resumes the transfer where it stopped.
- R11: A memory response with `mem_rerr` high pulses `evt_rd_err` once. The word is still delivered.
- R12: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` and `m_tdata` hold. A word counts as moved only on a cycle where both are high.
- R13: A size write while busy is ignored. Count, flag and the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 49 | Memory byte address (word aligned) |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| mem_rerr | input | 1 | Read error, valid with the read data |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | End-of-packet marker |
| evt_done | output | 1 | Transfer complete pulse |
| evt_mem_done | output | 1 | Memory side complete pulse |
| evt_rd_err | output | 1 | Memory read error pulse |

## Verification
A wrong count or address register shows at the ports on the very next word. Such a fault either fetches data from the wrong location, which the bench predicts per address, or changes the size readback that is checked after every handshake. A stuck busy or a missed decrement appears as a missing or extra done pulse within a few cycles of the final handshake. A bad pause or hold path shows as a stream word offered or changed in a cycle where none is allowed. Each of these is visible within one word time of about four cycles.

// File: rtl/m2s_dma_pkg.sv
`timescale 1ns/1ps
// Shared types and encodings for the memory-to-stream read channel.
// Assumes a 32-bit register port with a 3-bit index.
package m2s_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2,
        ST_SEND = 2'd3
    } fetch_st_e;

    localparam logic [2:0] RI_ADDR_LO = 3'd0;
    localparam logic [2:0] RI_ADDR_HI = 3'd1;
    localparam logic [2:0] RI_SIZE    = 3'd2;
    localparam logic [2:0] RI_CTRL    = 3'd3;
    localparam logic [2:0] RI_SUM     = 3'd4;
    localparam logic [2:0] RI_STAT    = 3'd5;

    localparam int CB_PAUSE_MEM  = 0;
    localparam int CB_PAUSE_STRM = 1;
    localparam int CB_FIXED      = 2;
    localparam int CB_SWAP       = 3;
    localparam int CTRL_W        = 4;

endpackage

// File: rtl/m2s_dma_bswap.sv
`timescale 1ns/1ps
// Byte-order reverser: optionally mirrors the byte lanes of a word.
// Assumes WORD_W is a multiple of 8. Purely combinational.
module m2s_dma_bswap #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] din,
    input  logic              swap_i,
    output logic [WORD_W-1:0] dout
);
    localparam int NB = WORD_W / 8;

    logic [WORD_W-1:0] mirrored;

    // Lane b of the output takes lane NB-1-b of the input.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign mirrored[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
    end

    // Select mirrored or straight word.
    assign dout = swap_i ? mirrored : din;

endmodule

// File: rtl/m2s_dma_regs.sv
`timescale 1ns/1ps
// Register file and transfer bookkeeping for the read channel.
// Holds the word address, remaining word count, last-word flag, control
// bits, checksum and busy. Steps count and address on each stream beat
// reported by the fetch engine. Assumes beat_i is only high while busy.
module m2s_dma_regs
    import m2s_dma_pkg::*;
#(
    parameter int HI_W  = 17,
    parameter int CNT_W = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_idx,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 beat_i,
    input  logic                 fetch_i,
    input  logic [31:0]          fetch_word_i,
    output logic                 busy_o,
    output logic [HI_W+31:0]     addr_o,
    output logic [CTRL_W-1:0]    ctrl_o,
    output logic                 last_flag_o,
    output logic                 final_o,
    output logic                 evt_done_o,
    output logic                 evt_mem_done_o
);
    localparam int AW_W = 30 + HI_W;

    logic [AW_W-1:0]   aw_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;
    logic              busy_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [31:0]       sum_q;
    logic              done_q;
    logic              mdone_q;

    logic              wr_size;
    logic [CNT_W-1:0]  new_cnt;

    // Start decode: size writes count only while idle.
    assign wr_size = reg_we && (reg_idx == RI_SIZE) && !busy_q;
    assign new_cnt = reg_wdata[CNT_W+1:2];

    // Transfer state: count, flag, busy, address and completion events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_q    <= '0;
            cnt_q   <= '0;
            last_q  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            mdone_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            mdone_q <= 1'b0;
            if (wr_size) begin
                cnt_q  <= new_cnt;
                last_q <= reg_wdata[0];
                if (new_cnt == '0) begin
                    done_q  <= 1'b1;
                    mdone_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q && beat_i) begin
                cnt_q <= cnt_q - 1'b1;
                if (!ctrl_q[CB_FIXED]) begin
                    aw_q <= aw_q + 1'b1;
                end
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    mdone_q <= 1'b1;
                end
            end
            if (reg_we && reg_idx == RI_ADDR_LO) begin
                aw_q[29:0] <= reg_wdata[31:2];
            end
            if (reg_we && reg_idx == RI_ADDR_HI) begin
                aw_q[AW_W-1:30] <= reg_wdata[HI_W-1:0];
            end
        end
    end

    // Control bits and checksum; a software write wins over accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sum_q  <= '0;
        end else begin
            if (reg_we && reg_idx == RI_CTRL) begin
                ctrl_q <= reg_wdata[CTRL_W-1:0];
            end
            if (fetch_i) begin
                sum_q <= sum_q + fetch_word_i;
            end
            if (reg_we && reg_idx == RI_SUM) begin
                sum_q <= reg_wdata;
            end
        end
    end

    // Register readback mux.
    always_comb begin
        case (reg_idx)
            RI_ADDR_LO: reg_rdata = {aw_q[29:0], 2'b00};
            RI_ADDR_HI: reg_rdata = {{(32-HI_W){1'b0}}, aw_q[AW_W-1:30]};
            RI_SIZE:    reg_rdata = {{(30-CNT_W){1'b0}}, cnt_q, 1'b0, last_q};
            RI_CTRL:    reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
            RI_SUM:     reg_rdata = sum_q;
            RI_STAT:    reg_rdata = {31'b0, busy_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign busy_o         = busy_q;
    assign addr_o         = {aw_q, 2'b00};
    assign ctrl_o         = ctrl_q;
    assign last_flag_o    = last_q;
    assign final_o        = (cnt_q == CNT_W'(1));
    assign evt_done_o     = done_q;
    assign evt_mem_done_o = mdone_q;

    // R5: every beat while busy removes exactly one word from the count.
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && beat_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: fixed mode leaves the address alone on a beat.
    p_fixed_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && beat_i && ctrl_q[CB_FIXED] && !(reg_we &&
         (reg_idx == RI_ADDR_LO || reg_idx == RI_ADDR_HI))) |=> $stable(aw_q));

    // R6: the final beat ends the transfer with both completion pulses.
    p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && beat_i && cnt_q == CNT_W'(1)) |=>
        (!busy_q && evt_done_o && evt_mem_done_o));

    // R4: a zero-length start completes without becoming busy.
    p_zero_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == RI_SIZE && !busy_q && reg_wdata[CNT_W+1:2] == '0)
        |=> (!busy_q && evt_done_o));

    // R13: a size write during a transfer changes neither count nor flag.
    p_busy_size_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && reg_we && reg_idx == RI_SIZE && !beat_i) |=>
        ($stable(cnt_q) && $stable(last_q)));

endmodule

// File: rtl/m2s_dma_fetch.sv
`timescale 1ns/1ps
// Fetch engine: one memory read per word, then one stream beat.
// Sequence per word: idle -> request -> response capture -> send.
// Assumes memory data and error are valid the cycle after mem_req.
module m2s_dma_fetch
    import m2s_dma_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              pause_i,
    input  logic              swap_i,
    input  logic              final_i,
    input  logic              last_flag_i,
    output logic              mem_req,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              fetch_o,
    output logic              beat_o,
    output logic              rd_err_o,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tlast
);
    fetch_st_e         state_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] shaped;

    m2s_dma_bswap #(.WORD_W(WORD_W)) u_bswap (
        .din    (mem_rdata),
        .swap_i (swap_i),
        .dout   (shaped)
    );

    // Word sequencer and output data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (busy_i && !pause_i) state_q <= ST_REQ;
                ST_REQ:  state_q <= ST_RESP;
                ST_RESP: begin
                    data_q  <= shaped;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (m_tready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (state_q == ST_REQ);
    assign fetch_o  = (state_q == ST_RESP);
    assign rd_err_o = (state_q == ST_RESP) && mem_rerr;
    assign m_tvalid = (state_q == ST_SEND);
    assign m_tdata  = data_q;
    assign m_tlast  = m_tvalid && final_i && last_flag_i;
    assign beat_o   = m_tvalid && m_tready;

    // R12: a stalled word stays offered and unchanged.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R10: no fetch leaves idle while a pause bit is set.
    p_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pause_i) |=> (state_q != ST_REQ));

    // R9: the end marker never appears without a word.
    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> (state_q == ST_SEND));

endmodule

// File: rtl/m2s_dma.sv
`timescale 1ns/1ps
// Memory-to-stream DMA read channel, top level.
// Joins the register/bookkeeping block to the fetch engine. Assumes a
// single-cycle-latency memory read port and a valid/ready stream sink.
module m2s_dma
    import m2s_dma_pkg::*;
#(
    parameter int HI_W  = 17,
    parameter int CNT_W = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_idx,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic [HI_W+31:0] mem_addr,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_rerr,
    output logic            m_tvalid,
    input  logic            m_tready,
    output logic [31:0]     m_tdata,
    output logic            m_tlast,
    output logic            evt_done,
    output logic            evt_mem_done,
    output logic            evt_rd_err
);
    logic              busy;
    logic              beat;
    logic              fetch;
    logic              final_word;
    logic              last_flag;
    logic [CTRL_W-1:0] ctrl;
    logic              paused;

    // Either pause bit holds off new fetches.
    assign paused = ctrl[CB_PAUSE_MEM] | ctrl[CB_PAUSE_STRM];

    m2s_dma_regs #(.HI_W(HI_W), .CNT_W(CNT_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_idx        (reg_idx),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .beat_i         (beat),
        .fetch_i        (fetch),
        .fetch_word_i   (mem_rdata),
        .busy_o         (busy),
        .addr_o         (mem_addr),
        .ctrl_o         (ctrl),
        .last_flag_o    (last_flag),
        .final_o        (final_word),
        .evt_done_o     (evt_done),
        .evt_mem_done_o (evt_mem_done)
    );

    m2s_dma_fetch #(.WORD_W(32)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .pause_i     (paused),
        .swap_i      (ctrl[CB_SWAP]),
        .final_i     (final_word),
        .last_flag_i (last_flag),
        .mem_req     (mem_req),
        .mem_rdata   (mem_rdata),
        .mem_rerr    (mem_rerr),
        .fetch_o     (fetch),
        .beat_o      (beat),
        .rd_err_o    (evt_rd_err),
        .m_tvalid    (m_tvalid),
        .m_tready    (m_tready),
        .m_tdata     (m_tdata),
        .m_tlast     (m_tlast)
    );

    // R3: a word is only offered during an active transfer.
    p_valid_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> busy);

endmodule

// File: tb/m2s_dma_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for the memory-to-stream read channel.
module m2s_dma_tb_top;
    localparam logic [2:0] I_LO = 3'd0, I_HI = 3'd1, I_SIZE = 3'd2,
                           I_CTRL = 3'd3, I_SUM = 3'd4, I_STAT = 3'd5;

    typedef struct packed {
        logic [31:0] lo;
        logic [16:0] hi;
        logic [7:0]  n;
        logic [3:0]  ctrl;
        logic        lastf;
        logic        stall;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{lo: 32'h0000_0100, hi: 17'd0, n: 8'd4, ctrl: 4'b0000, lastf: 1'b1, stall: 1'b0},
        '{lo: 32'h0000_0203, hi: 17'd0, n: 8'd3, ctrl: 4'b0100, lastf: 1'b0, stall: 1'b1},
        '{lo: 32'h0000_1000, hi: 17'd0, n: 8'd5, ctrl: 4'b1000, lastf: 1'b1, stall: 1'b1},
        '{lo: 32'hFFFF_FFF8, hi: 17'd1, n: 8'd4, ctrl: 4'b0000, lastf: 1'b0, stall: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [48:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [31:0] m_tdata;
    logic        m_tlast;
    logic        evt_done, evt_mem_done, evt_rd_err;

    logic [48:0] err_addr = '1;
    int n_chk = 0, n_fail = 0;
    int n_done = 0, n_mdone = 0, n_err = 0;

    always #10 clk = ~clk;

    m2s_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .evt_done(evt_done), .evt_mem_done(evt_mem_done),
        .evt_rd_err(evt_rd_err)
    );

    function automatic logic [31:0] memf(input logic [48:0] a);
        return (a[31:0] ^ 32'h1357_9BDF) + {a[48:32], 15'h1234};
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // Memory model: one-cycle read latency, error at one chosen address.
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memf(mem_addr);
            mem_rerr  <= (mem_addr == err_addr);
        end
    end

    // Event pulse counters.
    always @(posedge clk) begin
        if (rst_n) begin
            n_done  <= n_done + int'(evt_done);
            n_mdone <= n_mdone + int'(evt_mem_done);
            n_err   <= n_err + int'(evt_rd_err);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_idx = idx;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (m_tvalid) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [31:0] lo, input logic [16:0] hi,
                         input logic [3:0] ctrl);
        wr(I_CTRL, {28'b0, ctrl});
        wr(I_LO, lo);
        wr(I_HI, {15'b0, hi});
        wr(I_SUM, 32'h0);
    endtask

    task automatic collect(input logic [48:0] base, input int n, input bit fixed,
                           input bit swap, input bit lastf, input bit stall,
                           inout logic [31:0] sum);
        for (int w = 0; w < n; w++) begin
            logic [48:0] a;
            logic [31:0] raw, exp, d0, v;
            bit ok;
            a = fixed ? base : base + 49'(4 * w);
            raw = memf(a);
            exp = swap ? rev(raw) : raw;
            sum = sum + raw;
            wait_valid(ok);
            chk(ok, "R3 word offered", 64'(m_tvalid), 64'd1);
            if (stall) begin
                d0 = m_tdata;
                @(negedge clk);
                chk(m_tvalid && m_tdata == d0, "R12 held while stalled",
                    64'(m_tdata), 64'(d0));
            end
            chk(m_tdata == exp, swap ? "R8 swapped word" : "R3 word data",
                64'(m_tdata), 64'(exp));
            chk(m_tlast == (lastf && w == n - 1), "R9 end marker",
                64'(m_tlast), 64'(lastf && w == n - 1));
            m_tready = 1'b1;
            @(negedge clk);
            m_tready = 1'b0;
            rd(I_SIZE, v);
            chk(v == (32'((n - w - 1) * 4) | 32'(lastf)), "R5 size step",
                64'(v), 64'(32'((n - w - 1) * 4) | 32'(lastf)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, sum;
        logic [48:0] base, fin;
        int d0, m0, e0;
        bit seen;

        idle(5);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(I_STAT, v); chk(v == 0, "R3 reset busy clear", 64'(v), 64'd0);
        rd(I_SIZE, v); chk(v == 0, "R2 reset size", 64'(v), 64'd0);
        rd(I_CTRL, v); chk(v == 0, "R10 reset ctrl", 64'(v), 64'd0);
        chk(!m_tvalid, "R12 reset no valid", 64'(m_tvalid), 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = VECS[i];
            base = {t.hi, t.lo[31:2], 2'b00};
            setup(t.lo, t.hi, t.ctrl);
            rd(I_LO, v); chk(v == {t.lo[31:2], 2'b00}, "R1 low address", 64'(v), 64'(t.lo & ~32'h3));
            rd(I_HI, v); chk(v == {15'b0, t.hi}, "R1 high address", 64'(v), 64'(t.hi));
            d0 = n_done; m0 = n_mdone;
            sum = 32'h0;
            wr(I_SIZE, 32'(t.n) * 4 | 32'(t.lastf));
            rd(I_STAT, v); chk(v[0], "R3 busy after start", 64'(v), 64'd1);
            collect(base, int'(t.n), t.ctrl[2], t.ctrl[3], t.lastf, t.stall, sum);
            idle(3);
            rd(I_STAT, v); chk(v == 0, "R6 busy clears", 64'(v), 64'd0);
            chk(n_done == d0 + 1, "R6 done pulse", 64'(n_done - d0), 64'd1);
            chk(n_mdone == m0 + 1, "R6 mem done pulse", 64'(n_mdone - m0), 64'd1);
            rd(I_SUM, v); chk(v == sum, "R7 checksum", 64'(v), 64'(sum));
            fin = t.ctrl[2] ? base : base + 49'(4 * int'(t.n));
            rd(I_LO, v); chk(v == fin[31:0], "R5 final low address", 64'(v), 64'(fin[31:0]));
            rd(I_HI, v); chk(v == {15'b0, fin[48:32]}, "R5 final high address", 64'(v), 64'(fin[48:32]));
        end

        // R7: checksum register write and read
        wr(I_SUM, 32'hDEAD_BEEF);
        rd(I_SUM, v); chk(v == 32'hDEAD_BEEF, "R7 checksum write", 64'(v), 64'hDEADBEEF);

        // R4 and R2: zero-length start with stray bits
        d0 = n_done; m0 = n_mdone;
        wr(I_SIZE, 32'hE000_0003);
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (m_tvalid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R4 no word on zero size", 64'(seen), 64'd0);
        rd(I_STAT, v); chk(v == 0, "R4 busy stays clear", 64'(v), 64'd0);
        chk(n_done == d0 + 1, "R4 done pulse", 64'(n_done - d0), 64'd1);
        chk(n_mdone == m0 + 1, "R4 mem done pulse", 64'(n_mdone - m0), 64'd1);
        rd(I_SIZE, v); chk(v == 32'h1, "R2 size field and flag", 64'(v), 64'd1);

        // R10: pause bits hold off fetching
        setup(32'h400, 17'd0, 4'b0001);
        d0 = n_done;
        wr(I_SIZE, 32'd12);
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (m_tvalid || mem_req) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R10 memory pause holds", 64'(seen), 64'd0);
        rd(I_STAT, v); chk(v == 1, "R10 busy while paused", 64'(v), 64'd1);
        wr(I_CTRL, 32'h2);
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (m_tvalid || mem_req) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R10 stream pause holds", 64'(seen), 64'd0);
        wr(I_CTRL, 32'h0);
        sum = 32'h0;
        collect(49'h400, 3, 1'b0, 1'b0, 1'b0, 1'b0, sum);
        idle(3);
        chk(n_done == d0 + 1, "R10 resumed to completion", 64'(n_done - d0), 64'd1);

        // R13: size write during a transfer is ignored
        setup(32'h800, 17'd0, 4'b0000);
        d0 = n_done;
        wr(I_SIZE, 32'd16);
        idle(2);
        wr(I_SIZE, 32'd9);
        rd(I_SIZE, v); chk(v == 32'd16, "R13 size unchanged", 64'(v), 64'd16);
        sum = 32'h0;
        collect(49'h800, 4, 1'b0, 1'b0, 1'b0, 1'b0, sum);
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (m_tvalid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R13 no extra words", 64'(seen), 64'd0);
        chk(n_done == d0 + 1, "R13 single completion", 64'(n_done - d0), 64'd1);

        // R11: read error event
        err_addr = 49'hC04;
        e0 = n_err;
        setup(32'hC00, 17'd0, 4'b0000);
        wr(I_SIZE, 32'd12);
        sum = 32'h0;
        collect(49'hC00, 3, 1'b0, 1'b0, 1'b0, 1'b0, sum);
        idle(3);
        chk(n_err == e0 + 1, "R11 read error pulse", 64'(n_err - e0), 64'd1);
        rd(I_SUM, v); chk(v == sum, "R7 checksum after error", 64'(v), 64'(sum));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule